// File: doc/BRIEF.md
# Flash Byte-Program and Erase Sequencer

This block is a bus master that sits beside a byte-wide parallel flash and carries out one write-type operation per request: program a single byte, erase one 128-byte sector, or erase the whole array. The host hands over an operation code, a target address and a data byte with a valid/ready handshake. The block then emits the protective unlock write cycles that the flash demands, followed by the operation's own command cycle. After that it polls the target location until the flash reports that its internal operation has finished, and returns a one-cycle `done` pulse with two error flags.

Each flash bus access takes exactly one clock: a write cycle is one clock with `fl_we` high, and a read cycle is one clock with `fl_re` high, with `fl_rdata` sampled at the closing edge. Completion is found by reading the location over and over and watching bit 6, which the flash flips on every read while it is busy. When two consecutive reads show the same bit 6, the block does not yet trust that result. It reads twice more and accepts completion only when both extra reads agree. The number of status reads is bounded by `POLL_LIMIT`, and hitting that bound ends the operation with a timeout. A program can optionally be followed by a read-back compare.

The controller is one state machine with these states: IDLE (ready, waits for a request), CMD (one write cycle per step of the command table), POLL0 (first status read), POLL (compare bit 6 with the previous read), CONF1 and CONF2 (the two confirming reads), CHECK (read-back compare after a program), DONE (one-cycle result). The transitions are as follows:
- IDLE goes to CMD when a request is accepted.
- CMD loops until the last table step, then goes to POLL0.
- POLL0 goes to POLL.
- POLL goes to CONF1 when bit 6 did not change, and stays in POLL otherwise.
- CONF1 goes to CONF2.
- CONF2 goes to CHECK or DONE when both confirming reads match the stable value, and falls back to POLL otherwise.
- Any status read that uses up the read budget without completing goes to DONE with a timeout.
- CHECK goes to DONE.
- DONE goes back to IDLE.

Top module: `flash_wr_ctrl`

## Requirements
- R1: A program request (`req_op` = 0) drives exactly four write cycles on consecutive clocks, starting the clock after acceptance: (555h,AAh), (2AAh,55h), (555h,A0h), then (target address, data byte).
- R2: A sector erase request (`req_op` = 1) drives six consecutive write cycles: (555h,AAh), (2AAh,55h), (555h,80h), (555h,AAh), (2AAh,55h), then (target address, 20h). The flash clears the 128-byte sector holding that address.
- R3: A chip erase request (`req_op` = 2 or 3) drives the same first five write cycles as R2, then (555h,10h).
- R4: Status reads at the target address begin in the clock right after the last write cycle and repeat on every clock. A read whose bit 6 equals bit 6 of the previous read marks a candidate completion.
- R5: A candidate completion is followed by two more reads. `done` is raised only when both of those reads show the same bit 6 as the candidate. Otherwise polling resumes, so `done` never appears while the flash is still toggling bit 6.
- R6: When the status read numbered `POLL_LIMIT` (counted from the first read after the last write) does not complete the operation, the block ends with `done` and `err_timeout` high, having made exactly `POLL_LIMIT` status reads.
- R7: With `VERIFY_EN` = 1, a completed program is followed by one read of the target. `err_verify` is raised with `done` when that byte differs from the requested data. Erase operations never raise `err_verify`.
- R8: `req_ready` is high only in the idle state. A request is accepted when `req_valid` and `req_ready` are both high. Request inputs presented while `req_ready` is low have no effect. `done` lasts one clock and is followed by `req_ready` high.
- R9: `fl_we` and `fl_re` are never high in the same clock.
- R10: After reset, `req_ready` is 1 and `done`, `err_timeout`, `err_verify`, `fl_we` and `fl_re` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 program, 1 sector erase, 2/3 chip erase |
| req_addr | input | AW | Target byte or sector address |
| req_data | input | 8 | Byte to program |
| req_ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle end-of-operation pulse |
| err_timeout | output | 1 | Status read budget exhausted, valid with done |
| err_verify | output | 1 | Read-back mismatch after program, valid with done |
| fl_addr | output | AW | Flash address for the current bus cycle |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Write cycle in this clock |
| fl_re | output | 1 | Read cycle in this clock |
| fl_rdata | input | 8 | Flash read data, sampled at the end of a read cycle |

## Verification
The flash model in the bench toggles bit 6 on each read while it is busy. A plain program against this model shows the basic poll-until-stable path. A program in which the model withholds a single toggle creates a false stable pair, which separates a design that confirms with two extra reads from one that stops at the first match. Sector erase and chip erase are told apart by which array bytes end up erased and by their sixth write cycle. A flash that stores a corrupted byte exercises the read-back compare. A flash that stays busy beyond the budget checks the exact number of status reads made before the timeout. Request inputs held active during a sequence must leave the written cycle stream unchanged.

// File: rtl/fwc_pkg.sv
package fwc_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2
    } fwc_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_POLL0,
        ST_POLL,
        ST_CONF1,
        ST_CONF2,
        ST_CHECK,
        ST_DONE
    } fwc_state_e;

    localparam int          UNLK_W   = 11;
    localparam logic [10:0] UNLK_HI  = 11'h555;
    localparam logic [10:0] UNLK_LO  = 11'h2AA;
    localparam logic [7:0]  KEY_A    = 8'hAA;
    localparam logic [7:0]  KEY_B    = 8'h55;
    localparam logic [7:0]  CMD_PROG = 8'hA0;
    localparam logic [7:0]  CMD_ERAS = 8'h80;
    localparam logic [7:0]  CMD_SECT = 8'h20;
    localparam logic [7:0]  CMD_CHIP = 8'h10;
    localparam int          STEP_W   = 3;

endpackage

// File: rtl/fwc_cmd_seq.sv
module fwc_cmd_seq
    import fwc_pkg::*;
#(
    parameter int AW = 19
) (
    input  logic [1:0]        op,
    input  logic [STEP_W-1:0] step,
    input  logic [AW-1:0]     tgt_addr,
    input  logic [7:0]        tgt_data,
    output logic [AW-1:0]     cyc_addr,
    output logic [7:0]        cyc_data,
    output logic              cyc_last
);
    localparam int PAD = AW - UNLK_W;

    logic [AW-1:0] a_hi;
    logic [AW-1:0] a_lo;
    logic          is_prog;

    assign a_hi    = {{PAD{1'b0}}, UNLK_HI};
    assign a_lo    = {{PAD{1'b0}}, UNLK_LO};
    assign is_prog = (op == OP_PROG);

    always_comb begin
        cyc_last = is_prog ? (step == 3'd3) : (step == 3'd5);
        cyc_addr = a_hi;
        cyc_data = KEY_A;
        unique case (step)
            3'd0: begin cyc_addr = a_hi; cyc_data = KEY_A; end
            3'd1: begin cyc_addr = a_lo; cyc_data = KEY_B; end
            3'd2: begin cyc_addr = a_hi; cyc_data = is_prog ? CMD_PROG : CMD_ERAS; end
            3'd3: begin
                if (is_prog) begin
                    cyc_addr = tgt_addr;
                    cyc_data = tgt_data;
                end else begin
                    cyc_addr = a_hi;
                    cyc_data = KEY_A;
                end
            end
            3'd4: begin cyc_addr = a_lo; cyc_data = KEY_B; end
            3'd5: begin
                if (op == OP_SECT) begin
                    cyc_addr = tgt_addr;
                    cyc_data = CMD_SECT;
                end else begin
                    cyc_addr = a_hi;
                    cyc_data = CMD_CHIP;
                end
            end
            default: begin cyc_addr = a_hi; cyc_data = KEY_A; end
        endcase
    end
endmodule

// File: rtl/fwc_poll_timer.sv
module fwc_poll_timer #(
    parameter int LIMIT = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic last
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr)   cnt_q <= '0;
        else if (tick)  cnt_q <= cnt_q + 1'b1;
    end

    assign last = tick && (cnt_q == CW'(LIMIT - 1));

    // R6
    read_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (cnt_q < CW'(LIMIT)));
endmodule

// File: rtl/flash_wr_ctrl.sv
module flash_wr_ctrl
    import fwc_pkg::*;
#(
    parameter int AW         = 19,
    parameter int POLL_LIMIT = 2000,   // 20 us of one-clock reads at 100 MHz
    parameter bit VERIFY_EN  = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    output logic          req_ready,
    output logic          done,
    output logic          err_timeout,
    output logic          err_verify,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_wdata,
    output logic          fl_we,
    output logic          fl_re,
    input  logic [7:0]    fl_rdata
);
    fwc_state_e        state_q, state_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic [1:0]        op_q, op_d;
    logic [AW-1:0]     addr_q, addr_d;
    logic [7:0]        data_q, data_d;
    logic              prev6_q, prev6_d;
    logic              c1_q, c1_d;
    logic              eto_q, eto_d;
    logic              evf_q, evf_d;

    logic [AW-1:0] seq_addr;
    logic [7:0]    seq_data;
    logic          seq_last;
    logic          poll_rd;
    logic          tmo_last;
    logic          accept;
    logic          rd6;
    logic          complete;

    fwc_cmd_seq #(.AW(AW)) u_seq (
        .op       (op_q),
        .step     (step_q),
        .tgt_addr (addr_q),
        .tgt_data (data_q),
        .cyc_addr (seq_addr),
        .cyc_data (seq_data),
        .cyc_last (seq_last)
    );

    fwc_poll_timer #(.LIMIT(POLL_LIMIT)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .tick  (poll_rd),
        .last  (tmo_last)
    );

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign poll_rd  = (state_q == ST_POLL0) || (state_q == ST_POLL) ||
                      (state_q == ST_CONF1) || (state_q == ST_CONF2);
    assign rd6      = fl_rdata[6];
    assign complete = (state_q == ST_CONF2) && (rd6 == c1_q) && (c1_q == prev6_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            op_q    <= OP_PROG;
            addr_q  <= '0;
            data_q  <= '0;
            prev6_q <= 1'b0;
            c1_q    <= 1'b0;
            eto_q   <= 1'b0;
            evf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            op_q    <= op_d;
            addr_q  <= addr_d;
            data_q  <= data_d;
            prev6_q <= prev6_d;
            c1_q    <= c1_d;
            eto_q   <= eto_d;
            evf_q   <= evf_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        op_d    = op_q;
        addr_d  = addr_q;
        data_d  = data_q;
        prev6_d = prev6_q;
        c1_d    = c1_q;
        eto_d   = eto_q;
        evf_d   = evf_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = ST_CMD;
                    op_d    = req_op;
                    addr_d  = req_addr;
                    data_d  = req_data;
                    step_d  = '0;
                    eto_d   = 1'b0;
                    evf_d   = 1'b0;
                end
            end
            ST_CMD: begin
                if (seq_last) state_d = ST_POLL0;
                else          step_d  = step_q + 1'b1;
            end
            ST_POLL0: begin
                prev6_d = rd6;
                state_d = ST_POLL;
            end
            ST_POLL: begin
                if (rd6 == prev6_q) state_d = ST_CONF1;
                else                prev6_d = rd6;
            end
            ST_CONF1: begin
                c1_d    = rd6;
                state_d = ST_CONF2;
            end
            ST_CONF2: begin
                if (complete) begin
                    state_d = (VERIFY_EN && (op_q == OP_PROG)) ? ST_CHECK : ST_DONE;
                end else begin
                    prev6_d = rd6;
                    state_d = ST_POLL;
                end
            end
            ST_CHECK: begin
                evf_d   = (fl_rdata != data_q);
                state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        if (tmo_last && !complete) begin
            state_d = ST_DONE;
            eto_d   = 1'b1;
        end
    end

    // outputs
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        fl_we       = (state_q == ST_CMD);
        fl_re       = poll_rd || (state_q == ST_CHECK);
        fl_addr     = (state_q == ST_CMD) ? seq_addr : addr_q;
        fl_wdata    = seq_data;
        done        = (state_q == ST_DONE);
        err_timeout = (state_q == ST_DONE) && eto_q;
        err_verify  = (state_q == ST_DONE) && evf_q;
    end

    // R1
    first_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_ready) |->
            (fl_we && fl_addr == AW'(UNLK_HI) && fl_wdata == KEY_A));
    // R4
    poll_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_we) |-> fl_re);
    // R7
    verify_prog_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_verify |-> (op_q == OP_PROG));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));
    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fl_we, fl_re}));
endmodule

// File: tb/sim_flash_wr_ctrl.sv
module sim_flash_wr_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 19;
    localparam int LIMIT      = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = 8'h00;
    logic          req_ready, done, err_timeout, err_verify;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_wdata, fl_rdata;
    logic          fl_we, fl_re;

    int n_chk = 0;
    int n_fail = 0;
    int n_done = 0;

    // flash model controls (bench-driven)
    int busy_len = 12;
    int stall_at = -1;
    bit corrupt  = 1'b0;

    // flash model state
    logic [7:0] mem [256];
    int         busy;
    logic       tog, is_prog, pg_arm;
    logic [7:0] prog_true;
    int         er_n, rd_idx;

    logic [AW+7:0] exp_wr [$];
    logic [1:0]    exp_res [$];
    int            rd_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_wr_ctrl #(.AW(AW), .POLL_LIMIT(LIMIT), .VERIFY_EN(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_ready(req_ready),
        .done(done), .err_timeout(err_timeout), .err_verify(err_verify),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
        .fl_rdata(fl_rdata)
    );

    assign fl_rdata = (busy > 0) ? {(is_prog ? ~prog_true[7] : 1'b0), tog, 6'b0}
                                 : mem[fl_addr[7:0]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= i[7:0];
            busy <= 0; tog <= 1'b0; is_prog <= 1'b0; pg_arm <= 1'b0;
            prog_true <= 8'h00; er_n <= 0; rd_idx <= 0;
        end else begin
            if (busy > 0) busy <= busy - 1;
            if (fl_re) begin
                rd_idx <= rd_idx + 1;
                if (busy > 0 && rd_idx != stall_at) tog <= ~tog;
            end
            if (fl_we) begin
                rd_idx <= 0;
                if (pg_arm) begin
                    pg_arm <= 1'b0;
                    mem[fl_addr[7:0]] <= corrupt ? (fl_wdata ^ 8'h01) : fl_wdata;
                    prog_true <= fl_wdata;
                    is_prog <= 1'b1;
                    busy <= busy_len;
                end else if (fl_addr == AW'(11'h555) && fl_wdata == 8'hA0) begin
                    pg_arm <= 1'b1;
                end else if (fl_wdata == 8'h80) begin
                    er_n <= 1;
                end else if (er_n == 3) begin
                    er_n <= 0;
                    is_prog <= 1'b0;
                    busy <= busy_len;
                    if (fl_wdata == 8'h20) begin
                        for (int j = 0; j < 256; j++)
                            if (j[7] == fl_addr[7]) mem[j] <= 8'hFF;
                    end else if (fl_wdata == 8'h10) begin
                        for (int j = 0; j < 256; j++) mem[j] <= 8'hFF;
                    end
                end else if (er_n != 0) begin
                    er_n <= er_n + 1;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (fl_we) begin
                rd_cnt = 0;
                if (exp_wr.size() == 0) chk("R1 R2 R3 unexpected write", {fl_addr, fl_wdata}, 32'hFFFF_FFFF);
                else chk("R1 R2 R3 R8 write cycle", {fl_addr, fl_wdata}, exp_wr.pop_front());
            end
            if (fl_re) rd_cnt++;
            if (done) begin
                logic [1:0] er;
                er = (exp_res.size() != 0) ? exp_res.pop_front() : 2'b11;
                chk("R6 R7 result flags", {err_timeout, err_verify}, er);
                if (er[1]) chk("R6 status read count", rd_cnt, LIMIT);
                else       chk("R4 R5 done only after flash idle", (busy == 0), 1);
                n_done++;
            end
        end
    end

    task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                          input logic [1:0] res);
        int target;
        exp_wr.push_back({AW'(11'h555), 8'hAA});
        exp_wr.push_back({AW'(11'h2AA), 8'h55});
        if (op == 2'd0) begin
            exp_wr.push_back({AW'(11'h555), 8'hA0});
            exp_wr.push_back({a, d});
        end else begin
            exp_wr.push_back({AW'(11'h555), 8'h80});
            exp_wr.push_back({AW'(11'h555), 8'hAA});
            exp_wr.push_back({AW'(11'h2AA), 8'h55});
            if (op == 2'd1) exp_wr.push_back({a, 8'h20});
            else            exp_wr.push_back({AW'(11'h555), 8'h10});
        end
        exp_res.push_back(res);
        target = n_done + 1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        @(negedge clk);
        // R8: inputs held while busy must be ignored
        req_op = 2'd2; req_addr = AW'(8'h77); req_data = 8'hEE;
        repeat (4) @(negedge clk);
        req_valid = 1'b0;
        while (n_done < target) @(negedge clk);
        chk("R8 write queue drained", exp_wr.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 ready", req_ready, 1);
        chk("R10 done", done, 0);
        chk("R10 errors", {err_timeout, err_verify}, 0);
        chk("R10 strobes", {fl_we, fl_re}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 ready after release", req_ready, 1);

        // R1 plain program
        busy_len = 12;
        run_op(2'd0, AW'(8'h10), 8'h5A, 2'b00);
        chk("R1 programmed byte", mem[8'h10], 8'h5A);

        // R5 false stable pair from a withheld toggle
        busy_len = 20; stall_at = 1;
        run_op(2'd0, AW'(8'h20), 8'h33, 2'b00);
        chk("R5 programmed byte", mem[8'h20], 8'h33);
        stall_at = -1;

        // R2 sector erase of upper sector
        busy_len = 15;
        run_op(2'd1, AW'(8'h80), 8'h00, 2'b00);
        chk("R2 erased in sector", mem[8'h85], 8'hFF);
        chk("R2 erased sector end", mem[8'hFF], 8'hFF);
        chk("R2 other sector kept", mem[8'h10], 8'h5A);

        // R7 read-back mismatch
        busy_len = 10; corrupt = 1'b1;
        run_op(2'd0, AW'(8'h30), 8'hC3, 2'b01);
        corrupt = 1'b0;

        // R6 timeout
        busy_len = LIMIT * 2;
        run_op(2'd0, AW'(8'h40), 8'h11, 2'b10);
        repeat (LIMIT * 2 + 10) @(negedge clk);

        // R3 chip erase
        busy_len = 18;
        run_op(2'd3, AW'(8'h00), 8'h00, 2'b00);
        chk("R3 chip erased low", mem[8'h10], 8'hFF);
        chk("R3 chip erased high", mem[8'hC0], 8'hFF);

        // R7 verify passes after erase
        busy_len = 8;
        run_op(2'd0, AW'(8'h44), 8'h00, 2'b00);
        chk("R7 programmed zero", mem[8'h44], 8'h00);

        repeat (5) @(negedge clk);
        chk("R9 idle strobes", {fl_we, fl_re}, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule